// File: doc/BRIEF.md
# Configuration Unlock Window Decoder

This block decodes the bus side of an eight-port I/O window that normally belongs to a disk task file. A fixed handshake on that window opens a hidden path to a small bank of controller configuration registers. These registers hold two sets of read and write cycle timings, a control byte, a constant strap byte and a miscellaneous byte. While the window is closed, every access is flagged as passing through to the task file. The task file itself is not modelled.

While the window is open, a byte-wide access at port offset N reaches configuration register N. Word-wide accesses still pass through to the task file. Bit 0 of the miscellaneous register chooses which timing set the timing indices reach. The control byte decides whether drive 1 takes its timings from the second set. The drive-facing timing outputs are registered, so the timing logic sees stable values.

Top module: `cfg_window`

## Requirements
- R1: After a synchronous reset the window is closed, `rd_valid` and `tf_hit` are low, `rd_data` is 0x00, and all four drive timing outputs are 0x00.
- R2: The window opens (`cfg_open` high from the cycle after the write) only when this exact sequence occurs: two consecutive 16-bit reads of offset 1, then a byte write of 0x03 to offset 2. That key write is consumed and does not reach the task file.
- R3: Any other access made before the key write cancels the sequence, and the window stays closed. A further 16-bit read of offset 1 after the second one keeps the sequence armed.
- R4: While the window is open, a byte access at offset N reaches configuration register N and `tf_hit` stays low. A 16-bit access, or any access while closed, sets `tf_hit` and returns `rd_data` 0x00.
- R5: A byte write of 0x83 to offset 2 while the window is open closes it, from the next cycle onward.
- R6: Configuration reads are answered one cycle after the strobe with `rd_valid` high. The answers are: index 3 returns the control byte, index 6 returns the miscellaneous byte, index 5 (strap) returns 0x00, and indices 2, 4 and 7 return 0xFF.
- R7: Index 0 (read timing) and index 1 (write timing) reach the timing set chosen by bit 0 of the miscellaneous register: 0 selects set A and 1 selects set B. This applies to both writes and reads.
- R8: Writes to set B have no effect until a byte write of 0xC0 to offset 3 is made while the window is closed. That write also passes through to the task file.
- R9: When the control byte equals 0x85, drive 1 takes its timings from set B. Otherwise it takes them from set A. Drive 0 always uses set A. The drive outputs follow a register change one cycle later.
- R10: Writes to the strap index or to an unimplemented index change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_wide | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| io_ofs | input | 3 | Port offset within the window |
| io_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after `io_rd` |
| tf_hit | output | 1 | The previous access was routed to the task file |
| cfg_open | output | 1 | Configuration window open |
| drv0_rtim | output | 8 | Drive 0 read-cycle timing |
| drv0_wtim | output | 8 | Drive 0 write-cycle timing |
| drv1_rtim | output | 8 | Drive 1 read-cycle timing |
| drv1_wtim | output | 8 | Drive 1 write-cycle timing |
| ctrl_q | output | 8 | Control register contents |
| misc_q | output | 8 | Miscellaneous register contents |

## Verification
A wrong sequencer state shows up at once. On the next read, `tf_hit` and `rd_data` take the task-file answer where a configuration answer was expected, or the reverse, and `cfg_open` disagrees with the access history one cycle after the offending strobe. A misrouted timing write stays hidden until the other set is read back through index 0 or 1. It also appears on the drive outputs two cycles after the write. For that reason the bench reads both sets back after changing the set select, and it checks the drive outputs under both control values. The set-B gate is exercised both before and after the enabling write, because a gate that is stuck open looks correct on every other path.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ONE   = 2'd1,
    SEQ_ARMED = 2'd2,
    SEQ_OPEN  = 2'd3
  } seq_t;

  localparam int IDX_RTIM  = 0;
  localparam int IDX_WTIM  = 1;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_STRAP = 5;
  localparam int IDX_MISC  = 6;

  localparam int PROBE_OFS = 1;
  localparam int KEY_OFS   = 2;
  localparam int BEN_OFS   = 3;

endpackage

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import cfg_window_pkg::*;
#(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter logic [DW-1:0] OPEN_KEY  = 8'h03,
  parameter logic [DW-1:0] CLOSE_KEY = 8'h83
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic          acc_wide,
  input  logic [AW-1:0] acc_ofs,
  input  logic [DW-1:0] acc_wdata,
  output logic          open_q,
  output logic          key_eaten
);

  seq_t state_q, state_d;
  logic any_acc, probe_rd, open_wr, close_wr;

  assign any_acc  = acc_rd | acc_wr;
  assign probe_rd = acc_rd & acc_wide & (acc_ofs == AW'(PROBE_OFS));
  assign open_wr  = acc_wr & ~acc_wide & (acc_ofs == AW'(KEY_OFS)) & (acc_wdata == OPEN_KEY);
  assign close_wr = acc_wr & ~acc_wide & (acc_ofs == AW'(KEY_OFS)) & (acc_wdata == CLOSE_KEY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (probe_rd) state_d = SEQ_ONE;
      end
      SEQ_ONE: begin
        if (probe_rd)     state_d = SEQ_ARMED;
        else if (any_acc) state_d = SEQ_IDLE;
      end
      SEQ_ARMED: begin
        if (open_wr)       state_d = SEQ_OPEN;
        else if (probe_rd) state_d = SEQ_ARMED;
        else if (any_acc)  state_d = SEQ_IDLE;
      end
      SEQ_OPEN: begin
        if (close_wr) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= state_d;
  end

  assign open_q    = (state_q == SEQ_OPEN);
  assign key_eaten = ((state_q == SEQ_ARMED) & open_wr) | ((state_q == SEQ_OPEN) & close_wr);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_window_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int NSETS = 2,
  parameter logic [DW-1:0] STRAP_VAL = '0,
  localparam int SETW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr,
  input  logic [AW-1:0]             cfg_idx,
  input  logic [DW-1:0]             cfg_wdata,
  input  logic                      ben_wr,
  output logic [DW-1:0]             rd_val,
  output logic [DW-1:0]             ctrl_q,
  output logic [DW-1:0]             misc_q,
  output logic [NSETS-1:0][DW-1:0]  rtim_q,
  output logic [NSETS-1:0][DW-1:0]  wtim_q
);

  logic            ben_q;
  logic [SETW-1:0] sel;
  logic            sel_ok;
  logic            sel_wr_ok;

  assign sel       = misc_q[SETW-1:0];
  assign sel_ok    = (int'(sel) < NSETS);
  assign sel_wr_ok = sel_ok & ((sel == '0) | ben_q);

  always_ff @(posedge clk) begin
    if (rst)         ben_q <= 1'b0;
    else if (ben_wr) ben_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      misc_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_idx == AW'(IDX_CTRL)) ctrl_q <= cfg_wdata;
      if (cfg_idx == AW'(IDX_MISC)) misc_q <= cfg_wdata;
    end
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic hit;
    assign hit = cfg_wr & sel_wr_ok & (sel == SETW'(s));
    always_ff @(posedge clk) begin
      if (rst) begin
        rtim_q[s] <= '0;
        wtim_q[s] <= '0;
      end else if (hit) begin
        if (cfg_idx == AW'(IDX_RTIM)) rtim_q[s] <= cfg_wdata;
        if (cfg_idx == AW'(IDX_WTIM)) wtim_q[s] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    rd_val = '1;
    unique case (int'(cfg_idx))
      IDX_RTIM:  rd_val = sel_ok ? rtim_q[sel] : '1;
      IDX_WTIM:  rd_val = sel_ok ? wtim_q[sel] : '1;
      IDX_CTRL:  rd_val = ctrl_q;
      IDX_STRAP: rd_val = STRAP_VAL;
      IDX_MISC:  rd_val = misc_q;
      default:   rd_val = '1;
    endcase
  end

endmodule

// File: rtl/cfg_drive_map.sv
module cfg_drive_map #(
  parameter int DW    = 8,
  parameter int NSETS = 2,
  parameter logic [DW-1:0] SPLIT_KEY = 8'h85
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DW-1:0]            ctrl_q,
  input  logic [NSETS-1:0][DW-1:0] rtim_q,
  input  logic [NSETS-1:0][DW-1:0] wtim_q,
  output logic [DW-1:0]            drv0_rtim,
  output logic [DW-1:0]            drv0_wtim,
  output logic [DW-1:0]            drv1_rtim,
  output logic [DW-1:0]            drv1_wtim
);

  localparam int SET_B = (NSETS > 1) ? 1 : 0;

  logic split;
  assign split = (ctrl_q == SPLIT_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv0_rtim <= '0;
      drv0_wtim <= '0;
      drv1_rtim <= '0;
      drv1_wtim <= '0;
    end else begin
      drv0_rtim <= rtim_q[0];
      drv0_wtim <= wtim_q[0];
      drv1_rtim <= split ? rtim_q[SET_B] : rtim_q[0];
      drv1_wtim <= split ? wtim_q[SET_B] : wtim_q[0];
    end
  end

endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int NSETS = 2,
  parameter logic [DW-1:0] OPEN_KEY  = 8'h03,
  parameter logic [DW-1:0] CLOSE_KEY = 8'h83,
  parameter logic [DW-1:0] SPLIT_KEY = 8'h85,
  parameter logic [DW-1:0] BEN_KEY   = 8'hC0,
  parameter logic [DW-1:0] STRAP_VAL = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic          io_wide,
  input  logic [AW-1:0] io_ofs,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          tf_hit,
  output logic          cfg_open,
  output logic [DW-1:0] drv0_rtim,
  output logic [DW-1:0] drv0_wtim,
  output logic [DW-1:0] drv1_rtim,
  output logic [DW-1:0] drv1_wtim,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] misc_q
);

  logic                     win_open, key_eaten;
  logic                     any_acc, byte_cfg, tf_pass, ben_wr;
  logic [DW-1:0]            rd_val;
  logic [NSETS-1:0][DW-1:0] rtim_q, wtim_q;

  cfg_unlock_seq #(
    .AW(AW), .DW(DW), .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .acc_rd    (io_rd),
    .acc_wr    (io_wr),
    .acc_wide  (io_wide),
    .acc_ofs   (io_ofs),
    .acc_wdata (io_wdata),
    .open_q    (win_open),
    .key_eaten (key_eaten)
  );

  assign any_acc  = io_rd | io_wr;
  assign byte_cfg = win_open & ~io_wide & any_acc & ~key_eaten;
  assign tf_pass  = any_acc & ~byte_cfg & ~key_eaten;
  assign ben_wr   = io_wr & ~io_wide & ~win_open &
                    (io_ofs == AW'(BEN_OFS)) & (io_wdata == BEN_KEY);

  cfg_regfile #(
    .AW(AW), .DW(DW), .NSETS(NSETS), .STRAP_VAL(STRAP_VAL)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (byte_cfg & io_wr),
    .cfg_idx   (io_ofs),
    .cfg_wdata (io_wdata),
    .ben_wr    (ben_wr),
    .rd_val    (rd_val),
    .ctrl_q    (ctrl_q),
    .misc_q    (misc_q),
    .rtim_q    (rtim_q),
    .wtim_q    (wtim_q)
  );

  cfg_drive_map #(
    .DW(DW), .NSETS(NSETS), .SPLIT_KEY(SPLIT_KEY)
  ) u_map (
    .clk       (clk),
    .rst       (rst),
    .ctrl_q    (ctrl_q),
    .rtim_q    (rtim_q),
    .wtim_q    (wtim_q),
    .drv0_rtim (drv0_rtim),
    .drv0_wtim (drv0_wtim),
    .drv1_rtim (drv1_rtim),
    .drv1_wtim (drv1_wtim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      tf_hit   <= 1'b0;
    end else begin
      rd_valid <= io_rd;
      tf_hit   <= tf_pass;
      rd_data  <= (io_rd & byte_cfg) ? rd_val : '0;
    end
  end

  assign cfg_open = win_open;

endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          io_rd,
  input logic          io_wr,
  input logic          io_wide,
  input logic [AW-1:0] io_ofs,
  input logic [DW-1:0] io_wdata,
  input logic          cfg_open,
  input logic          tf_hit,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data
);

  // R1: the first cycle after reset shows a closed, quiet window
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!cfg_open && !tf_hit && !rd_valid));

  // R2: the window only opens right after the opening key write
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(io_wr && !io_wide && io_ofs == AW'(2) && io_wdata == DW'(8'h03)));

  // R4: byte accesses in an open window never reach the task file
  a_r4_byte_stays_inside: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && (io_rd || io_wr) && !io_wide && io_ofs != AW'(2)) |=> !tf_hit);

  // R5: the closing key shuts the window
  a_r5_close_key: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && io_wr && !io_wide && io_ofs == AW'(2) && io_wdata == DW'(8'h83)) |=> !cfg_open);

  // R6: the strap index reads as zero
  a_r6_strap_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && io_rd && !io_wide && io_ofs == AW'(5)) |=> (rd_valid && rd_data == '0));

endmodule

bind cfg_window cfg_window_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_rd    (io_rd),
  .io_wr    (io_wr),
  .io_wide  (io_wide),
  .io_ofs   (io_ofs),
  .io_wdata (io_wdata),
  .cfg_open (cfg_open),
  .tf_hit   (tf_hit),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/cfg_window_bench.sv
module cfg_window_bench;

  localparam real CYC = 4.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_rd = 1'b0, io_wr = 1'b0, io_wide = 1'b0;
  logic [2:0] io_ofs = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] rd_data, drv0_rtim, drv0_wtim, drv1_rtim, drv1_wtim, ctrl_q, misc_q;
  logic       rd_valid, tf_hit, cfg_open;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_data[$];
  logic       exp_tf[$];
  string      exp_req[$];

  always #(CYC/2) clk = ~clk;

  cfg_window u_cfg_window (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_wr(io_wr), .io_wide(io_wide),
    .io_ofs(io_ofs), .io_wdata(io_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .tf_hit(tf_hit), .cfg_open(cfg_open), .drv0_rtim(drv0_rtim), .drv0_wtim(drv0_wtim),
    .drv1_rtim(drv1_rtim), .drv1_wtim(drv1_wtim), .ctrl_q(ctrl_q), .misc_q(misc_q)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design answers
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_data.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: actual %02h expected none", rd_data);
      end else begin
        logic [7:0] d; logic t; string r;
        d = exp_data.pop_front(); t = exp_tf.pop_front(); r = exp_req.pop_front();
        check(r, rd_data, d);
        check(r, {7'd0, tf_hit}, {7'd0, t});
      end
    end
  end

  task automatic rd(logic wide, logic [2:0] ofs, logic [7:0] ed, logic et, string req);
    @(negedge clk);
    exp_data.push_back(ed); exp_tf.push_back(et); exp_req.push_back(req);
    io_rd = 1'b1; io_wide = wide; io_ofs = ofs;
    @(negedge clk);
    io_rd = 1'b0; io_wide = 1'b0;
  endtask

  task automatic wr(logic [2:0] ofs, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_wide = 1'b0; io_ofs = ofs; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic unlock(string req);
    rd(1'b1, 3'd1, 8'h00, 1'b1, req);
    rd(1'b1, 3'd1, 8'h00, 1'b1, req);
    wr(3'd2, 8'h03);
  endtask

  initial begin
    #(CYC * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", {7'd0, cfg_open}, 8'h00);
    check("R1", {6'd0, rd_valid, tf_hit}, 8'h00);
    check("R1", rd_data, 8'h00);
    check("R1", drv0_rtim | drv0_wtim | drv1_rtim | drv1_wtim, 8'h00);

    // R4 locked byte read goes to task file
    rd(1'b0, 3'd5, 8'h00, 1'b1, "R4");
    // R3 broken sequences
    rd(1'b1, 3'd1, 8'h00, 1'b1, "R3");
    wr(3'd2, 8'h03);
    check("R3", {7'd0, cfg_open}, 8'h00);
    rd(1'b1, 3'd1, 8'h00, 1'b1, "R3");
    rd(1'b0, 3'd0, 8'h00, 1'b1, "R3");
    rd(1'b1, 3'd1, 8'h00, 1'b1, "R3");
    wr(3'd2, 8'h03);
    check("R3", {7'd0, cfg_open}, 8'h00);
    // R3 third probe read keeps the sequence armed; R2 opens
    rd(1'b1, 3'd1, 8'h00, 1'b1, "R3");
    unlock("R2");
    check("R2", {7'd0, cfg_open}, 8'h01);

    // R6 read decoding
    rd(1'b0, 3'd5, 8'h00, 1'b0, "R6");
    rd(1'b0, 3'd2, 8'hFF, 1'b0, "R6");
    rd(1'b0, 3'd4, 8'hFF, 1'b0, "R6");
    rd(1'b0, 3'd7, 8'hFF, 1'b0, "R6");
    rd(1'b0, 3'd3, 8'h00, 1'b0, "R6");
    // R10 ignored writes
    wr(3'd5, 8'h5A);
    wr(3'd7, 8'h11);
    rd(1'b0, 3'd5, 8'h00, 1'b0, "R10");
    rd(1'b0, 3'd7, 8'hFF, 1'b0, "R10");

    // R7 set A programming
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h31);
    wr(3'd1, 8'h32);
    rd(1'b0, 3'd0, 8'h31, 1'b0, "R7");
    rd(1'b0, 3'd1, 8'h32, 1'b0, "R7");
    // R8 set B locked out
    wr(3'd6, 8'h01);
    wr(3'd0, 8'h44);
    rd(1'b0, 3'd0, 8'h00, 1'b0, "R8");
    rd(1'b0, 3'd6, 8'h01, 1'b0, "R6");
    // R4 word access passes through while open
    rd(1'b1, 3'd0, 8'h00, 1'b1, "R4");
    // R5 close
    wr(3'd2, 8'h83);
    check("R5", {7'd0, cfg_open}, 8'h00);
    rd(1'b0, 3'd0, 8'h00, 1'b1, "R5");

    // R8 enable set B, then program it
    wr(3'd3, 8'hC0);
    unlock("R8");
    wr(3'd0, 8'h44);
    wr(3'd1, 8'h45);
    rd(1'b0, 3'd0, 8'h44, 1'b0, "R8");
    rd(1'b0, 3'd1, 8'h45, 1'b0, "R8");
    wr(3'd6, 8'h00);
    rd(1'b0, 3'd0, 8'h31, 1'b0, "R7");

    // R9 mapping
    @(negedge clk);
    check("R9", drv1_rtim, 8'h31);
    check("R9", drv1_wtim, 8'h32);
    wr(3'd3, 8'h85);
    @(negedge clk);
    check("R9", drv0_rtim, 8'h31);
    check("R9", drv0_wtim, 8'h32);
    check("R9", drv1_rtim, 8'h44);
    check("R9", drv1_wtim, 8'h45);
    rd(1'b0, 3'd3, 8'h85, 1'b0, "R6");
    wr(3'd2, 8'h83);

    repeat (3) @(negedge clk);
    check("scoreboard", 8'(exp_data.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule